// File: doc/BRIEF.md
# Signal Level and Alarm Supervisor

This block sits after the receive-level threshold comparators and a set of abnormal-condition detectors. It decides when the trip channel and the guard channel of the receiver may produce outputs. An out-of-range level, whether too weak or too strong, blocks the trip channel at once. A weak level can also be passed to the unblocking logic as a single request pulse, which that logic turns into a low-signal trip. This routing is enabled by a configuration input.

The abnormal-condition flags are combined with OR. The combined condition must persist for a programmable number of clock cycles before the alarm is raised. If the condition goes away before that count completes, the count restarts from zero. While the alarm is active, both channels are blocked. The alarm releases only after the condition has stayed clear for a second programmable number of cycles, and both blocks release in that same cycle.

Top module: `level_alarm_supervisor`

## Requirements
- R1: `trip_block` is high in every cycle in which `lvl_weak` or `lvl_strong` is high, with no clock delay.
- R2: While `alarm` is low, `guard_block` is low and `trip_block` equals `lvl_weak | lvl_strong`.
- R3: `unblock_request` is high for exactly one cycle when `lvl_weak` is high and was low at the previous rising clock edge, and only if `unblock_en` is high. It is never high while `unblock_en` is low.
- R4: The condition is the OR of all bits of `abn_flags`. `alarm` rises right after the rising edge that samples the condition high for the `arm_cycles`-th consecutive time. An `arm_cycles` of 0 acts as 1.
- R5: A single rising edge that samples the condition low, before the count completes, restarts the arming count from zero, and no alarm is raised.
- R6: While `alarm` is high, both `guard_block` and `trip_block` are high, whatever the level inputs are.
- R7: `alarm` falls right after the rising edge that samples the condition low for the `clear_cycles`-th consecutive time. A sample with the condition high restarts this count. Both blocks release in the same cycle that `alarm` falls.
- R8: While `rst_n` is low, `alarm` and `guard_block` are low and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_weak | input | 1 | Level-too-low comparator flag |
| lvl_strong | input | 1 | Level-too-high comparator flag |
| abn_flags | input | NFLAG | Abnormal-condition flags, ORed together |
| unblock_en | input | 1 | Routes weak-level rises to the unblocking logic |
| arm_cycles | input | TW | Persistence count before the alarm is raised |
| clear_cycles | input | TW | Clear count before the alarm drops out |
| trip_block | output | 1 | Blocks the trip channel |
| guard_block | output | 1 | Blocks the guard channel |
| alarm | output | 1 | Alarm active |
| unblock_request | output | 1 | One-cycle low-signal trip request |

## Verification
The bench holds the condition for one cycle fewer than the arming count, and then for exactly the full count. A design with an off-by-one counter raises the alarm early or late. A single clear cycle is inserted in the middle of both the arming count and the clearing count. A design that pauses its count instead of restarting it raises or drops the alarm too soon. The request pulse is examined with the enable off, while the weak level is held, and when both levels are high together. A level-triggered or ungated request would then show up as a stuck or spurious pulse. An arming count of zero is also applied, which catches a design that waits for a counter wrap.

// File: rtl/level_alarm_supervisor.sv
module level_alarm_supervisor #(
  parameter int NFLAG = 4,
  parameter int TW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_weak,
  input  logic             lvl_strong,
  input  logic [NFLAG-1:0] abn_flags,
  input  logic             unblock_en,
  input  logic [TW-1:0]    arm_cycles,
  input  logic [TW-1:0]    clear_cycles,
  output logic             trip_block,
  output logic             guard_block,
  output logic             alarm,
  output logic             unblock_request
);
  localparam int CW = TW + 1;

  logic          cond, run, hit, weak_q;
  logic [TW-1:0] cnt, limit;

  assign cond  = |abn_flags;
  assign limit = alarm ? clear_cycles : arm_cycles;
  assign run   = alarm ? ~cond : cond;
  assign hit   = ({1'b0, cnt} + CW'(1)) >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      alarm <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
    end else if (hit) begin
      cnt   <= '0;
      alarm <= ~alarm;
    end else begin
      cnt <= cnt + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) weak_q <= 1'b0;
    else        weak_q <= lvl_weak;
  end

  assign trip_block      = lvl_weak | lvl_strong | alarm;
  assign guard_block     = alarm;
  assign unblock_request = unblock_en & lvl_weak & ~weak_q;
endmodule

// File: rtl/level_alarm_supervisor_chk.sv
module level_alarm_supervisor_chk #(
  parameter int NFLAG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lvl_weak,
  input logic             lvl_strong,
  input logic [NFLAG-1:0] abn_flags,
  input logic             unblock_en,
  input logic             trip_block,
  input logic             guard_block,
  input logic             alarm,
  input logic             unblock_request
);
  a_r1_level_blocks_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_weak || lvl_strong) |-> trip_block);
  a_r2_no_guard_block_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm |-> !guard_block);
  a_r3_request_gated: assert property (@(posedge clk) disable iff (!rst_n)
    unblock_request |-> (unblock_en && lvl_weak));
  a_r3_request_single: assert property (@(posedge clk) disable iff (!rst_n)
    unblock_request |=> !unblock_request);
  a_r4_rise_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(|abn_flags));
  a_r6_alarm_blocks_both: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> (guard_block && trip_block));
  a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> !$past(|abn_flags));
endmodule

bind level_alarm_supervisor level_alarm_supervisor_chk #(.NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_weak(lvl_weak), .lvl_strong(lvl_strong),
  .abn_flags(abn_flags), .unblock_en(unblock_en), .trip_block(trip_block),
  .guard_block(guard_block), .alarm(alarm), .unblock_request(unblock_request)
);

// File: tb/level_alarm_supervisor_test.sv
module level_alarm_supervisor_test;
  localparam int NFLAG = 4;
  localparam int TW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lvl_weak = 1'b0, lvl_strong = 1'b0, unblock_en = 1'b0;
  logic [NFLAG-1:0] abn_flags = '0;
  logic [TW-1:0] arm_cycles = 16'd5, clear_cycles = 16'd3;
  logic trip_block, guard_block, alarm, unblock_request;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  level_alarm_supervisor #(.NFLAG(NFLAG), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .lvl_weak(lvl_weak), .lvl_strong(lvl_strong),
    .abn_flags(abn_flags), .unblock_en(unblock_en), .arm_cycles(arm_cycles),
    .clear_cycles(clear_cycles), .trip_block(trip_block),
    .guard_block(guard_block), .alarm(alarm), .unblock_request(unblock_request)
  );

  // {weak, strong, en, exp_trip, exp_guard, exp_req}
  localparam logic [5:0] VEC [10] = '{
    6'b000_000, 6'b010_100, 6'b100_100, 6'b001_000, 6'b101_101,
    6'b101_100, 6'b111_100, 6'b001_000, 6'b111_101, 6'b000_000
  };

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R8: reset state
    wait_neg(2);
    check("R8 alarm", alarm, 1'b0);
    check("R8 guard_block", guard_block, 1'b0);
    rst_n = 1'b1;
    wait_neg(1);

    // R1 R2 R3: vector table
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      {lvl_weak, lvl_strong, unblock_en} = VEC[v][5:3];
      #2;
      check("R1 trip_block", trip_block, VEC[v][2]);
      check("R2 guard_block", guard_block, VEC[v][1]);
      check("R3 unblock_request", unblock_request, VEC[v][0]);
    end
    {lvl_weak, lvl_strong, unblock_en} = 3'b000;

    // R5: a single clear sample restarts the arming count
    @(negedge clk); abn_flags = 4'b0100;
    wait_neg(4); check("R5 no alarm at 4", alarm, 1'b0);
    abn_flags = 4'b0000;
    wait_neg(1);
    abn_flags = 4'b0001;
    wait_neg(4); check("R5 restarted count", alarm, 1'b0);
    // R4: alarm after five consecutive samples
    wait_neg(1); check("R4 alarm raised", alarm, 1'b1);
    // R6: both blocked, levels clear
    #2;
    check("R6 guard_block", guard_block, 1'b1);
    check("R6 trip_block", trip_block, 1'b1);

    // R7: dropout restart and release
    @(negedge clk); abn_flags = 4'b0000;
    wait_neg(2); check("R7 still alarm at 2", alarm, 1'b1);
    abn_flags = 4'b1000;
    wait_neg(1);
    abn_flags = 4'b0000;
    wait_neg(2); check("R7 restarted dropout", alarm, 1'b1);
    wait_neg(1);
    check("R7 alarm dropped", alarm, 1'b0);
    check("R7 guard released", guard_block, 1'b0);
    check("R7 trip released", trip_block, 1'b0);

    // R4: zero arming count acts as one
    arm_cycles = '0;
    abn_flags = 4'b0010;
    wait_neg(1); check("R4 zero preset", alarm, 1'b1);
    abn_flags = 4'b0000;
    wait_neg(3); check("R7 drop after zero preset", alarm, 0);

    // R3: held weak level issues no request
    lvl_weak = 1'b1; unblock_en = 1'b1;
    #2; check("R3 rise pulse", unblock_request, 1'b1);
    wait_neg(3); check("R3 held level", unblock_request, 1'b0);

    finish_run();
  end
endmodule